// File: doc/BRIEF.md
# GPIO Bank with Latched Edge Interrupts

This block is one memory-mapped bank of general-purpose pins, up to 32 of them, with the pin count set by a parameter. Software drives the pins through two separate write windows. In the set window, each 1 bit turns a bit on. In the clear window, each 1 bit turns a bit off. Because of this, output-enable and data-out bits can be changed without a read-modify-write sequence. The bank samples its inputs through a two-flop synchroniser, and the synchronised levels can be read back.

Each pin has its own enable for rising-edge detection and its own enable for falling-edge detection. An edge on a pin with the matching enable sets a sticky cause bit. A separate per-pin event mask decides which cause bits reach the single interrupt output, which may be shared with other devices. To acknowledge an interrupt, software writes the masked-cause value it read back to a write-one-to-clear register.

The bus has a 2-bit window select (0 main, 1 cause, 2 set, 3 clear) and an 8-bit byte offset. Reads return their data one cycle after the request.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, all pins are undriven with output data low, the interrupt is low, and every register reads zero.
- R2: In window 2, a write to offset 0x00 sets each output-enable bit where write data is 1, and a write to 0x04 does the same for data-out. Zero bits leave state unchanged. Reads of 0x00 and 0x04 in window 2 or 3 return the current output-enable and data-out values.
- R3: In window 3, a write to offset 0x00 clears each output-enable bit where write data is 1, and 0x04 does the same for data-out. Zero bits leave state unchanged.
- R4: In window 0, offset 0x00 is the read/write rising-edge enable and 0x04 is the read/write falling-edge enable. Offset 0x08 returns the synchronised input levels, and writes to it are ignored.
- R5: A 0-to-1 change on a pin with its rise enable set, or a 1-to-0 change with its fall enable set, sets that pin's cause bit. With both enables set, either edge sets it. With neither set, no edge sets it.
- R6: In window 1, offset 0x00 reads as cause AND event-enable, and writes to it are ignored. Offset 0x14 is the read/write event enable.
- R7: In window 1, writing offset 0x18 clears each cause bit where write data is 1. Offset 0x18 reads as zero.
- R8: The interrupt is high exactly when some cause bit and its event-enable bit are both set. Clearing an event-enable bit masks that cause without erasing it, so setting the enable again brings it back.
- R9: When an edge and a clear reach the same cause bit in the same cycle, the bit stays set.
- R10: Bits at or above the configured pin count read as zero and ignore writes.
- R11: Reads of offsets that are not mapped in the selected window return zero.
- R12: A read request produces valid read data with the valid flag high in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_window | input | 2 | Window select: 0 main, 1 cause, 2 set, 3 clear |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_oe | output | PIN_COUNT | Output enable per pin |
| pin_out | output | PIN_COUNT | Output data per pin |
| irq | output | 1 | Interrupt request, OR of the masked causes |

## Verification
The bench times a clear-cause write to land in the same cycle as a freshly synchronised edge on an already-set bit. A design where the clear wins would read that bit back as zero. It drops the event enable while a cause is pending and then restores it. A design that wipes the cause when it masks it would never raise the interrupt again. It uses a 24-pin instance with all-ones writes to catch upper bits that are stored or read back. It also drives edges on pins with only the opposite enable, or with no enable, to catch detectors that ignore the edge polarity. Writes to the read-only input view and masked-cause view, and reads of unmapped offsets, expose decoders that alias registers.

// File: rtl/gpio_edge_pkg.sv
// Package: shared widths, window codes and register offsets of the GPIO bank.
// Assumes: a 32-bit data bus and byte offsets of 8 bits.
package gpio_edge_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        WIN_MAIN  = 2'd0,
        WIN_CAUSE = 2'd1,
        WIN_SET   = 2'd2,
        WIN_CLR   = 2'd3
    } win_e;

    localparam logic [ADDR_W-1:0] OFF_RISE_EN  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_FALL_EN  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_LEVELS   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_PENDING  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_EVT_EN   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_ACK      = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_DRIVE_EN = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_DRIVE_LV = 8'h04;

endpackage

// File: rtl/gpio_edge_sync.sv
// Module: two-flop input synchroniser followed by a previous-sample stage.
// It produces one-cycle rise and fall pulses for each pin.
// Assumes: pins change slower than the clock. Outputs are zero-extended to DATA_W.
module gpio_edge_sync
    import gpio_edge_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [DATA_W-1:0]    level,
    output logic [DATA_W-1:0]    rise_ev,
    output logic [DATA_W-1:0]    fall_ev
);

    for (genvar p = 0; p < DATA_W; p++) begin : g_pin
        if (p < PIN_COUNT) begin : g_live
            logic meta_q, sync_q, prev_q;

            // Resample the pin twice, then keep the previous synchronised level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= pin_in[p];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end

            assign level[p]   = sync_q;
            assign rise_ev[p] = sync_q & ~prev_q;
            assign fall_ev[p] = ~sync_q & prev_q;
        end else begin : g_idle
            assign level[p]   = 1'b0;
            assign rise_ev[p] = 1'b0;
            assign fall_ev[p] = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_edge_cause.sv
// Module: qualifies edge pulses with the per-pin polarity enables and latches them
// into sticky cause bits. Cause bits are cleared by write-one-to-clear, and a new
// edge wins over a clear in the same cycle. The event mask drives the interrupt.
// Assumes: the clear vector is a single-cycle pulse already masked to live pins.
module gpio_edge_cause
    import gpio_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rise_ev,
    input  logic [DATA_W-1:0] fall_ev,
    input  logic [DATA_W-1:0] rise_en,
    input  logic [DATA_W-1:0] fall_en,
    input  logic [DATA_W-1:0] evt_en,
    input  logic [DATA_W-1:0] ack_mask,
    output logic [DATA_W-1:0] pending,
    output logic              irq
);

    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] hits;

    // Select the edges whose polarity is enabled on their pin.
    always_comb hits = (rise_ev & rise_en) | (fall_ev & fall_en);

    // Latch hits. Acknowledged bits drop unless a new hit arrives at the same time.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~ack_mask) | hits;
    end

    // Apply the event mask and collapse to one request line.
    always_comb begin
        pending = cause_q & evt_en;
        irq     = |pending;
    end

    assert_hit_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |=> ((cause_q & $past(hits)) == $past(hits)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mask != '0) |=> ((cause_q & $past(ack_mask & ~hits)) == '0));

    assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cause_q) & ~cause_q & ~$past(ack_mask)) == '0));

endmodule

// File: rtl/gpio_edge_regs.sv
// Module: bus decoder and register file. It holds the drive enables, drive levels,
// polarity enables and event mask, and it returns read data one cycle after the request.
// Assumes: one access per bus_valid pulse. Bits at or above PIN_COUNT are forced to zero.
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_window,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [DATA_W-1:0] level,
    input  logic [DATA_W-1:0] pending,
    output logic [DATA_W-1:0] drive_en,
    output logic [DATA_W-1:0] drive_lv,
    output logic [DATA_W-1:0] rise_en,
    output logic [DATA_W-1:0] fall_en,
    output logic [DATA_W-1:0] evt_en,
    output logic [DATA_W-1:0] ack_mask
);

    localparam logic [DATA_W:0]   ONE_WIDE = (DATA_W+1)'(1) << PIN_COUNT;
    localparam logic [DATA_W-1:0] PIN_MASK = DATA_W'(ONE_WIDE - (DATA_W+1)'(1));

    win_e              win;
    logic              wr, rd;
    logic [DATA_W-1:0] wbits;
    logic [DATA_W-1:0] rmux;

    // Decode the request and restrict write data to live pins.
    always_comb begin
        win   = win_e'(bus_window);
        wr    = bus_valid & bus_write;
        rd    = bus_valid & ~bus_write;
        wbits = bus_wdata & PIN_MASK;
    end

    // Apply set and clear windows to the drive enable and drive level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_en <= '0;
            drive_lv <= '0;
        end else if (wr && win == WIN_SET) begin
            if (bus_addr == OFF_DRIVE_EN) drive_en <= drive_en | wbits;
            if (bus_addr == OFF_DRIVE_LV) drive_lv <= drive_lv | wbits;
        end else if (wr && win == WIN_CLR) begin
            if (bus_addr == OFF_DRIVE_EN) drive_en <= drive_en & ~wbits;
            if (bus_addr == OFF_DRIVE_LV) drive_lv <= drive_lv & ~wbits;
        end
    end

    // Store the polarity enables and the event mask on plain writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            evt_en  <= '0;
        end else if (wr) begin
            if (win == WIN_MAIN  && bus_addr == OFF_RISE_EN) rise_en <= wbits;
            if (win == WIN_MAIN  && bus_addr == OFF_FALL_EN) fall_en <= wbits;
            if (win == WIN_CAUSE && bus_addr == OFF_EVT_EN)  evt_en  <= wbits;
        end
    end

    // Produce a one-cycle acknowledge pulse for the write-one-to-clear offset.
    always_comb ack_mask = (wr && win == WIN_CAUSE && bus_addr == OFF_ACK) ? wbits : '0;

    // Select read data. Unmapped offsets give zero.
    always_comb begin
        rmux = '0;
        unique case (win)
            WIN_MAIN: begin
                if (bus_addr == OFF_RISE_EN) rmux = rise_en;
                if (bus_addr == OFF_FALL_EN) rmux = fall_en;
                if (bus_addr == OFF_LEVELS)  rmux = level;
            end
            WIN_CAUSE: begin
                if (bus_addr == OFF_PENDING) rmux = pending;
                if (bus_addr == OFF_EVT_EN)  rmux = evt_en;
            end
            WIN_SET, WIN_CLR: begin
                if (bus_addr == OFF_DRIVE_EN) rmux = drive_en;
                if (bus_addr == OFF_DRIVE_LV) rmux = drive_lv;
            end
            default: rmux = '0;
        endcase
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= rd ? (rmux & PIN_MASK) : '0;
            bus_rvalid <= rd;
        end
    end

    assert_set_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && win == WIN_SET && bus_addr == OFF_DRIVE_EN)
        |=> ((drive_en & $past(wbits)) == $past(wbits)));

    assert_clr_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && win == WIN_CLR && bus_addr == OFF_DRIVE_LV)
        |=> ((drive_lv & $past(wbits)) == '0));

    assert_upper_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((drive_en | drive_lv | rise_en | fall_en | evt_en | bus_rdata) & ~PIN_MASK) == '0);

    assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bus_rvalid == $past(rd)));

endmodule

// File: rtl/gpio_edge_ctrl.sv
// Module: top of the GPIO bank. It joins the synchroniser, cause latch and register file.
// Assumes: PIN_COUNT is between 1 and 32, and the bus is a single-cycle strobe interface.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [1:0]           bus_window,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic                 irq
);

    logic [DATA_W-1:0] level, rise_ev, fall_ev;
    logic [DATA_W-1:0] drive_en, drive_lv, rise_en, fall_en, evt_en, ack_mask, pending;

    gpio_edge_sync #(.PIN_COUNT(PIN_COUNT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .level   (level),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    gpio_edge_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .evt_en   (evt_en),
        .ack_mask (ack_mask),
        .pending  (pending),
        .irq      (irq)
    );

    gpio_edge_regs #(.PIN_COUNT(PIN_COUNT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_window (bus_window),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .level      (level),
        .pending    (pending),
        .drive_en   (drive_en),
        .drive_lv   (drive_lv),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .evt_en     (evt_en),
        .ack_mask   (ack_mask)
    );

    // Bring the live pin slice of the drive registers out to the pads.
    always_comb begin
        pin_oe  = drive_en[PIN_COUNT-1:0];
        pin_out = drive_lv[PIN_COUNT-1:0];
    end

    assert_irq_needs_read_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_window == 2'd1 && bus_addr == 8'h00 && irq)
        |=> (bus_rdata != '0));

endmodule

// File: tb/gpio_edge_ctrl_bench.sv
// Scoreboard bench: read tasks queue expected words, and a monitor compares them on bus_rvalid.
module gpio_edge_ctrl_bench;

    localparam int PINS = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [1:0]        bus_window = 2'd0;
    logic [7:0]        bus_addr = 8'h00;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [PINS-1:0]   pin_in = '0;
    logic [PINS-1:0]   pin_oe;
    logic [PINS-1:0]   pin_out;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } expect_t;
    expect_t sb[$];

    always #2.5 clk = ~clk;

    gpio_edge_ctrl #(.PIN_COUNT(PINS)) u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_window(bus_window), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_window = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] w, input logic [7:0] a, input logic [31:0] e,
                          input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_window = w; bus_addr = a;
        sb.push_back('{tag: tag, exp: e});
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each returned word with the oldest expectation.
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (sb.size() == 0) begin
                check("R12 unexpected read data", 32'h1, 32'h0);
            end else begin
                expect_t it;
                it = sb.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        check("R1 oe", 32'(pin_oe), 32'h0);
        check("R1 out", 32'(pin_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        bus_rd(2'd0, 8'h00, 32'h0, "R1 rise");
        bus_rd(2'd0, 8'h04, 32'h0, "R1 fall");
        bus_rd(2'd1, 8'h14, 32'h0, "R1 evt");
        bus_rd(2'd1, 8'h00, 32'h0, "R1 pending");
        bus_rd(2'd2, 8'h00, 32'h0, "R1 drive en");

        // R2 and R10: set window, upper bits dropped.
        bus_wr(2'd2, 8'h00, 32'hA5A5_5A5A);
        check("R2 R10 oe set", 32'(pin_oe), 32'h00A5_5A5A);
        bus_wr(2'd2, 8'h04, 32'h0000_0F0F);
        check("R2 out set", 32'(pin_out), 32'h0000_0F0F);
        bus_wr(2'd2, 8'h00, 32'h0000_0001);
        check("R2 zero bits keep", 32'(pin_oe), 32'h00A5_5A5B);
        bus_rd(2'd2, 8'h00, 32'h00A5_5A5B, "R2 readback set win");

        // R3: clear window.
        bus_wr(2'd3, 8'h00, 32'h0000_5A5A);
        check("R3 oe clr", 32'(pin_oe), 32'h00A5_0001);
        bus_wr(2'd3, 8'h04, 32'h0000_0F00);
        check("R3 out clr", 32'(pin_out), 32'h0000_000F);
        bus_rd(2'd3, 8'h04, 32'h0000_000F, "R3 readback clr win");

        // R4: synchronised input view, read-only.
        pin_in = 24'h12_3456;
        settle();
        bus_rd(2'd0, 8'h08, 32'h0012_3456, "R4 levels");
        bus_wr(2'd0, 8'h08, 32'hFFFF_FFFF);
        bus_rd(2'd0, 8'h08, 32'h0012_3456, "R4 levels read-only");
        pin_in = '0;
        settle();

        // R5: edges with no enables leave no cause.
        bus_wr(2'd1, 8'h14, 32'hFFFF_FFFF);
        bus_rd(2'd1, 8'h14, 32'h00FF_FFFF, "R10 evt upper");
        bus_rd(2'd1, 8'h00, 32'h0, "R5 no enable no cause");
        check("R5 irq quiet", 32'(irq), 32'h0);

        // R4 and R10: polarity enables.
        bus_wr(2'd0, 8'h00, 32'hFFFF_FFFF);
        bus_rd(2'd0, 8'h00, 32'h00FF_FFFF, "R10 rise upper");
        bus_wr(2'd0, 8'h00, 32'h0000_0005);
        bus_wr(2'd0, 8'h04, 32'h0000_0006);
        bus_rd(2'd0, 8'h04, 32'h0000_0006, "R4 fall en");

        // R5: rising edges on pins 0-3. Only pins 0 and 2 have rise enabled.
        pin_in = 24'h00_000F;
        settle();
        bus_rd(2'd1, 8'h00, 32'h0000_0005, "R5 rise");
        check("R8 irq on", 32'(irq), 32'h1);
        // Falling edges: pins 1 and 2 have fall enabled.
        pin_in = '0;
        settle();
        bus_rd(2'd1, 8'h00, 32'h0000_0007, "R5 fall and both");

        // R7: write back to acknowledge.
        bus_wr(2'd1, 8'h18, 32'h0000_0007);
        check("R7 irq off", 32'(irq), 32'h0);
        bus_rd(2'd1, 8'h00, 32'h0, "R7 cleared");
        bus_rd(2'd1, 8'h18, 32'h0, "R7 ack reads zero");

        // R8: masking keeps the cause.
        pin_in = 24'h00_0001;
        settle();
        check("R8 irq", 32'(irq), 32'h1);
        bus_wr(2'd1, 8'h14, 32'h0);
        check("R8 masked irq", 32'(irq), 32'h0);
        bus_rd(2'd1, 8'h00, 32'h0, "R8 masked pending");
        bus_wr(2'd1, 8'h14, 32'h0000_0001);
        check("R8 unmasked irq", 32'(irq), 32'h1);
        bus_rd(2'd1, 8'h00, 32'h0000_0001, "R8 cause kept");
        bus_wr(2'd1, 8'h18, 32'h0000_0001);
        check("R8 irq after ack", 32'(irq), 32'h0);

        // R6: the pending view ignores writes.
        bus_wr(2'd1, 8'h00, 32'h0000_00FF);
        bus_rd(2'd1, 8'h00, 32'h0, "R6 pending read-only");

        // R9: a clear that meets a new edge in the same cycle.
        pin_in = '0;
        settle();
        pin_in = 24'h00_0001;
        settle();
        check("R9 setup irq", 32'(irq), 32'h1);
        pin_in = '0;
        settle();
        pin_in = 24'h00_0001;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_window = 2'd1; bus_addr = 8'h18;
        bus_wdata = 32'h0000_0001;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R9 edge wins irq", 32'(irq), 32'h1);
        bus_rd(2'd1, 8'h00, 32'h0000_0001, "R9 edge wins");
        bus_wr(2'd1, 8'h18, 32'h0000_0001);
        bus_rd(2'd1, 8'h00, 32'h0, "R9 later clear");

        // R11: unmapped offsets.
        bus_rd(2'd0, 8'h0C, 32'h0, "R11 main 0x0C");
        bus_rd(2'd1, 8'h04, 32'h0, "R11 cause 0x04");
        bus_rd(2'd2, 8'h10, 32'h0, "R11 set 0x10");

        // R12: every queued read has returned.
        @(negedge clk);
        @(negedge clk);
        check("R12 all reads returned", 32'(sb.size()), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule